// File: doc/BRIEF.md
# Watchdog Mode Controller with Guarded Debug Entry

This block supervises a microcontroller with a software watchdog that has no window: once it is running, the software must write the timing register before a fixed timeout expires. If no configuring access ever arrives after power-up, the block keeps issuing reset pulses to the microcontroller at a steady period. Every timeout also pulls a separate active-low fault output low. That output stays low until software writes the timing register again.

Commands arrive already deframed from a serial link, one per cycle, as a 3-bit register address, a write flag and a 4-bit data nibble. A debug mode that turns the watchdog off can be reached only by an ordered sequence after a power-up. The software first writes the timing register to reach normal mode. It then writes 0000 to the mode-control register while the battery-fail flag is still set, which arms debug. A further mode-control write then picks one of three debug sub-modes. Reading the mode-control register clears the battery-fail flag, and after that the watchdog cannot be disabled until the next power-up.

Top module: `wdm_ctrl`

## Requirements
- R1: While `por_n_i` is low and just after it is released, `mode_o` is 0 (normal-request), `batt_fail_o` is 1, and both `mcu_rst_n_o` and `wdog_fault_n_o` are 1.
- R2: In normal-request mode with no timing-register write, `mcu_rst_n_o` falls once every TICK_DIV*WD_TICKS+RST_LEN clock cycles, and each low pulse lasts RST_LEN cycles.
- R3: A write (write flag 1) to address TIM_ADDR in normal-request mode sets `mode_o` to 1 (normal) and restarts the timeout count.
- R4: A write of data 0000 to mode-control address 000 arms debug only in normal mode while `batt_fail_o` is 1. Debug can be entered only while armed.
- R5: While armed, or while already in debug, a mode-control write whose low three data bits are 101, 110 or 111 sets `mode_o` to 5 (normal debug), 6 (standby debug) or 7 (stop debug). Data bit 3 is ignored.
- R6: While `mode_o` is a debug mode (bit 2 set), no timeout occurs: `mcu_rst_n_o` and `wdog_fault_n_o` stay 1 however long it lasts.
- R7: A mode-control write of 0000 in any debug mode returns `mode_o` to 1 and disarms. The timeout then fires TICK_DIV*WD_TICKS cycles later unless the timing register is written.
- R8: On a timeout, `wdog_fault_n_o` goes 0 and stays 0 until a write to TIM_ADDR is accepted.
- R9: A read (write flag 0) of address 000 clears `batt_fail_o`. Only a power-up sets it again, so later 0000 writes cannot arm debug.
- R10: In normal mode, TIM_ADDR writes spaced less than TICK_DIV*WD_TICKS cycles apart prevent any reset. TICK_DIV*WD_TICKS cycles after the last such write, a timeout starts a reset pulse and returns `mode_o` to 0.
- R11: Commands that arrive while `mcu_rst_n_o` is 0 have no effect.
- R12: Reads other than the mode-control read, writes to other addresses, and out-of-order mode-control writes (sub-mode select without arming, 0000 in normal-request mode) change neither `mode_o` nor the arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Active-low power-up reset |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_addr_i | input | 3 | Register address |
| cmd_wr_i | input | 1 | 1 = write, 0 = read |
| cmd_data_i | input | 4 | Write data nibble |
| mode_o | output | 3 | 0 normal-request, 1 normal, 5/6/7 debug sub-modes |
| batt_fail_o | output | 1 | Battery-fail flag |
| mcu_rst_n_o | output | 1 | Active-low reset pulse to the microcontroller |
| wdog_fault_n_o | output | 1 | Active-low latched watchdog fault |

## Verification
The timeout is tested with silence after power-up, with regular timing-register writes, and with a single final write. These patterns separate the free-running reset period from the restart of the count and from the exact expiry distance. The debug sequence is run in order, with the sub-mode select sent before arming, with arming tried in normal-request mode, and with a mode-control read before arming. This shows that only the ordered path after power-up turns off the watchdog. Commands sent during a reset pulse, and reads of the timing register, show that the fault latch is cleared only by an accepted timing-register write.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

   typedef enum logic [2:0] {
      MODE_NREQ     = 3'd0,
      MODE_NORMAL   = 3'd1,
      MODE_DBG_NORM = 3'd5,
      MODE_DBG_STBY = 3'd6,
      MODE_DBG_STOP = 3'd7
   } wdm_mode_e;

   localparam logic [2:0] MCR_ADDR = 3'b000;

   function automatic logic is_debug(input wdm_mode_e m);
      return m[2];
   endfunction

   function automatic logic is_sub_sel(input logic [3:0] d);
      return (d[2:0] == 3'b101) || (d[2:0] == 3'b110) || (d[2:0] == 3'b111);
   endfunction

endpackage

// File: rtl/wdm_prescaler.sv
module wdm_prescaler #(
   parameter int TICK_DIV = 4
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic clr_i,
   output logic tick_o
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (TICK_DIV == 1) begin : g_direct
         assign tick_o = !clr_i;
      end else begin : g_count
         localparam int DW = $clog2(TICK_DIV);
         localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i)             div_q <= '0;
            else if (clr_i)           div_q <= '0;
            else if (div_q == LAST)   div_q <= '0;
            else                      div_q <= div_q + 1'b1;
         end
         assign tick_o = !clr_i && (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdm_timer.sv
module wdm_timer #(
   parameter int TICK_DIV = 4,
   parameter int WD_TICKS = 50,
   parameter int RST_LEN  = 8
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic run_i,
   input  logic kick_i,
   output logic expire_o,
   output logic pulse_o
);
   localparam int TW = (WD_TICKS > 1) ? $clog2(WD_TICKS) : 1;
   localparam int RW = $clog2(RST_LEN + 1);
   localparam logic [TW-1:0] T_LAST = TW'(WD_TICKS - 1);
   localparam logic [RW-1:0] R_LOAD = RW'(RST_LEN);

   generate
      if (WD_TICKS < 2) begin : g_bad_ticks
         $error("WD_TICKS must be at least 2");
      end
      if (RST_LEN < 1) begin : g_bad_len
         $error("RST_LEN must be at least 1");
      end
   endgenerate

   logic          tick;
   logic          clr;
   logic [TW-1:0] tcnt_q;
   logic [RW-1:0] rcnt_q;

   assign pulse_o = (rcnt_q != '0);
   assign clr     = kick_i || !run_i || pulse_o;

   wdm_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
      .clk_i  (clk_i),
      .rst_n_i(rst_n_i),
      .clr_i  (clr),
      .tick_o (tick)
   );

   assign expire_o = !clr && tick && (tcnt_q == T_LAST);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)       tcnt_q <= '0;
      else if (clr)       tcnt_q <= '0;
      else if (tick)      tcnt_q <= (tcnt_q == T_LAST) ? '0 : tcnt_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)       rcnt_q <= '0;
      else if (expire_o)  rcnt_q <= R_LOAD;
      else if (pulse_o)   rcnt_q <= rcnt_q - 1'b1;
   end
endmodule

// File: rtl/wdm_mode_fsm.sv
module wdm_mode_fsm
   import wdm_pkg::*;
#(
   parameter logic [2:0] TIM_ADDR = 3'b011
) (
   input  logic      clk_i,
   input  logic      rst_n_i,
   input  logic      cmd_valid_i,
   input  logic [2:0] cmd_addr_i,
   input  logic      cmd_wr_i,
   input  logic [3:0] cmd_data_i,
   input  logic      block_i,
   input  logic      expire_i,
   output wdm_mode_e mode_o,
   output logic      armed_o,
   output logic      batt_fail_o,
   output logic      tim_wr_o,
   output logic      kick_o
);
   generate
      if (TIM_ADDR == MCR_ADDR) begin : g_bad_addr
         $error("TIM_ADDR must differ from the mode-control address");
      end
   endgenerate

   logic      acc, mcr_wr, mcr_rd;
   wdm_mode_e mode_q, mode_d;
   logic      armed_q, armed_d;
   logic      batt_q;

   assign acc      = cmd_valid_i && !block_i;
   assign mcr_wr   = acc &&  cmd_wr_i && (cmd_addr_i == MCR_ADDR);
   assign mcr_rd   = acc && !cmd_wr_i && (cmd_addr_i == MCR_ADDR);
   assign tim_wr_o = acc &&  cmd_wr_i && (cmd_addr_i == TIM_ADDR);
   assign kick_o   = tim_wr_o && !is_debug(mode_q);

   always_comb begin
      mode_d  = mode_q;
      armed_d = armed_q;
      if (expire_i) begin
         mode_d  = MODE_NREQ;
         armed_d = 1'b0;
      end else begin
         unique case (mode_q)
            MODE_NREQ: begin
               if (tim_wr_o) mode_d = MODE_NORMAL;
            end
            MODE_NORMAL: begin
               if (mcr_wr && cmd_data_i == 4'b0000 && batt_q)
                  armed_d = 1'b1;
               else if (mcr_wr && armed_q && is_sub_sel(cmd_data_i))
                  mode_d = wdm_mode_e'(cmd_data_i[2:0]);
            end
            MODE_DBG_NORM, MODE_DBG_STBY, MODE_DBG_STOP: begin
               if (mcr_wr && cmd_data_i == 4'b0000) begin
                  mode_d  = MODE_NORMAL;
                  armed_d = 1'b0;
               end else if (mcr_wr && is_sub_sel(cmd_data_i)) begin
                  mode_d = wdm_mode_e'(cmd_data_i[2:0]);
               end
            end
            default: begin
               mode_d  = MODE_NREQ;
               armed_d = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         mode_q  <= MODE_NREQ;
         armed_q <= 1'b0;
         batt_q  <= 1'b1;
      end else begin
         mode_q  <= mode_d;
         armed_q <= armed_d;
         if (mcr_rd) batt_q <= 1'b0;
      end
   end

   assign mode_o      = mode_q;
   assign armed_o     = armed_q;
   assign batt_fail_o = batt_q;
endmodule

// File: rtl/wdm_ctrl.sv
module wdm_ctrl
   import wdm_pkg::*;
#(
   parameter int         TICK_DIV = 4,
   parameter int         WD_TICKS = 50,
   parameter int         RST_LEN  = 8,
   parameter logic [2:0] TIM_ADDR = 3'b011
) (
   input  logic       clk_i,
   input  logic       por_n_i,
   input  logic       cmd_valid_i,
   input  logic [2:0] cmd_addr_i,
   input  logic       cmd_wr_i,
   input  logic [3:0] cmd_data_i,
   output logic [2:0] mode_o,
   output logic       batt_fail_o,
   output logic       mcu_rst_n_o,
   output logic       wdog_fault_n_o
);
   wdm_mode_e mode_w;
   logic      armed_w, expire_w, pulse_w, tim_wr_w, kick_w, run_w;
   logic      fault_n_q;

   assign run_w = !is_debug(mode_w);

   wdm_timer #(
      .TICK_DIV(TICK_DIV),
      .WD_TICKS(WD_TICKS),
      .RST_LEN (RST_LEN)
   ) u_timer (
      .clk_i   (clk_i),
      .rst_n_i (por_n_i),
      .run_i   (run_w),
      .kick_i  (kick_w),
      .expire_o(expire_w),
      .pulse_o (pulse_w)
   );

   wdm_mode_fsm #(.TIM_ADDR(TIM_ADDR)) u_fsm (
      .clk_i      (clk_i),
      .rst_n_i    (por_n_i),
      .cmd_valid_i(cmd_valid_i),
      .cmd_addr_i (cmd_addr_i),
      .cmd_wr_i   (cmd_wr_i),
      .cmd_data_i (cmd_data_i),
      .block_i    (pulse_w),
      .expire_i   (expire_w),
      .mode_o     (mode_w),
      .armed_o    (armed_w),
      .batt_fail_o(batt_fail_o),
      .tim_wr_o   (tim_wr_w),
      .kick_o     (kick_w)
   );

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)      fault_n_q <= 1'b1;
      else if (expire_w) fault_n_q <= 1'b0;
      else if (tim_wr_w) fault_n_q <= 1'b1;
   end

   assign mode_o         = mode_w;
   assign mcu_rst_n_o    = !pulse_w;
   assign wdog_fault_n_o = fault_n_q;
endmodule

// File: rtl/wdm_ctrl_chk.sv
module wdm_ctrl_chk #(
   parameter logic [2:0] TIM_ADDR = 3'b011
) (
   input logic       clk,
   input logic       por_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_addr,
   input logic       cmd_wr,
   input logic [2:0] mode,
   input logic       batt_fail,
   input logic       mcu_rst_n,
   input logic       fault_n,
   input logic       expire,
   input logic       armed
);
   a_r11_pulse_in_nreq: assert property (@(posedge clk) disable iff (!por_n)
      !mcu_rst_n |-> (mode == 3'd0) && !fault_n);

   a_r6_no_expiry_in_debug: assert property (@(posedge clk) disable iff (!por_n)
      mode[2] |-> !expire);

   a_r9_batt_stays_clear: assert property (@(posedge clk) disable iff (!por_n)
      !batt_fail |=> !batt_fail);

   a_r9_batt_clear_by_read: assert property (@(posedge clk) disable iff (!por_n)
      $fell(batt_fail) |-> $past(cmd_valid && !cmd_wr && cmd_addr == 3'b000));

   a_r4_debug_needs_arm: assert property (@(posedge clk) disable iff (!por_n)
      $rose(mode[2]) |-> $past(armed));

   a_r8_fault_held: assert property (@(posedge clk) disable iff (!por_n)
      (!fault_n && !(cmd_valid && cmd_wr && cmd_addr == TIM_ADDR)) |=> !fault_n);

   a_r10_expiry_to_nreq: assert property (@(posedge clk) disable iff (!por_n)
      expire |=> (mode == 3'd0) && !mcu_rst_n && !fault_n);
endmodule

bind wdm_ctrl wdm_ctrl_chk #(.TIM_ADDR(TIM_ADDR)) u_chk (
   .clk      (clk_i),
   .por_n    (por_n_i),
   .cmd_valid(cmd_valid_i),
   .cmd_addr (cmd_addr_i),
   .cmd_wr   (cmd_wr_i),
   .mode     (mode_o),
   .batt_fail(batt_fail_o),
   .mcu_rst_n(mcu_rst_n_o),
   .fault_n  (wdog_fault_n_o),
   .expire   (expire_w),
   .armed    (armed_w)
);

// File: tb/wdm_ctrl_bench.sv
`timescale 1ns/1ps
module wdm_ctrl_bench;
   localparam int         TD   = 2;
   localparam int         WT   = 20;
   localparam int         RL   = 5;
   localparam logic [2:0] TIM  = 3'b011;
   localparam int         TOUT = TD * WT;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_addr = '0;
   logic       cmd_wr = 1'b0;
   logic [3:0] cmd_data = '0;
   logic [2:0] mode;
   logic       batt_fail, mcu_rst_n, fault_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   wdm_ctrl #(.TICK_DIV(TD), .WD_TICKS(WT), .RST_LEN(RL), .TIM_ADDR(TIM)) u_wdm_ctrl (
      .clk_i(clk), .por_n_i(por_n), .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr),
      .cmd_wr_i(cmd_wr), .cmd_data_i(cmd_data), .mode_o(mode),
      .batt_fail_o(batt_fail), .mcu_rst_n_o(mcu_rst_n), .wdog_fault_n_o(fault_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic eq(input string tag, input int act, input int exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic power_up();
      @(negedge clk);
      por_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
   endtask

   task automatic cmd(input logic [2:0] a, input logic w, input logic [3:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_addr = a; cmd_wr = w; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_wr = 1'b0; cmd_addr = '0; cmd_data = '0;
   endtask

   task automatic cycles_until(input logic lvl, output int n);
      n = 0;
      while (mcu_rst_n !== lvl && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      eq("R1 mode in reset", mode, 0);
      eq("R1 batt in reset", batt_fail, 1);
      por_n = 1'b1;
      @(negedge clk);
      eq("R1 mode after release", mode, 0);
      eq("R1 batt after release", batt_fail, 1);
      eq("R1 rst_n after release", mcu_rst_n, 1);
      eq("R1 fault_n after release", fault_n, 1);
   endtask

   task automatic t_periodic();
      int a, b, w;
      power_up();
      cycles_until(1'b0, w);
      eq("R2 first timeout", w, TOUT);
      eq("R8 fault low on timeout", fault_n, 0);
      cycles_until(1'b1, a);
      eq("R2 pulse length", a, RL);
      cycles_until(1'b0, b);
      eq("R2 reset period", a + b, TOUT + RL);
      eq("R2 mode stays nreq", mode, 0);
      repeat (RL + 1) @(negedge clk);
      cmd(TIM, 1'b0, 4'h0);
      eq("R8 fault kept by read", fault_n, 0);
      cmd(TIM, 1'b1, 4'h0);
      eq("R8 fault released by write", fault_n, 1);
      eq("R3 mode normal", mode, 1);
   endtask

   task automatic t_kick();
      int w;
      bit stayed = 1;
      power_up();
      cmd(TIM, 1'b1, 4'h0);
      eq("R3 normal after write", mode, 1);
      for (int k = 0; k < 6; k++) begin
         for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (!mcu_rst_n) stayed = 0;
         end
         cmd(TIM, 1'b1, 4'h0);
      end
      eq("R10 no reset while kicked", stayed, 1);
      cycles_until(1'b0, w);
      eq("R10 expiry after last kick", w, TOUT);
      eq("R10 back to nreq", mode, 0);
   endtask

   task automatic t_debug();
      int w;
      bit quiet = 1;
      power_up();
      cmd(TIM, 1'b1, 4'h0);
      cmd(3'b000, 1'b1, 4'b0000);
      eq("R4 arm keeps normal", mode, 1);
      cmd(3'b000, 1'b1, 4'b1101);
      eq("R5 normal debug, bit3 ignored", mode, 5);
      for (int c = 0; c < 4 * TOUT; c++) begin
         @(negedge clk);
         if (!mcu_rst_n || !fault_n) quiet = 0;
      end
      eq("R6 no timeout in debug", quiet, 1);
      cmd(3'b000, 1'b1, 4'b0110);
      eq("R5 standby debug", mode, 6);
      cmd(3'b000, 1'b1, 4'b0111);
      eq("R5 stop debug", mode, 7);
      cmd(3'b000, 1'b1, 4'b0000);
      eq("R7 exit to normal", mode, 1);
      cycles_until(1'b0, w);
      eq("R7 watchdog live again", w, TOUT);
   endtask

   task automatic t_locked();
      power_up();
      cmd(TIM, 1'b1, 4'h0);
      cmd(3'b000, 1'b0, 4'h0);
      eq("R9 read clears batt", batt_fail, 0);
      cmd(3'b000, 1'b1, 4'b0000);
      cmd(3'b000, 1'b1, 4'b0101);
      eq("R9 debug refused after read", mode, 1);
   endtask

   task automatic t_ignore();
      power_up();
      cmd(3'b000, 1'b1, 4'b0101);
      eq("R12 select in nreq ignored", mode, 0);
      cmd(TIM, 1'b0, 4'h0);
      eq("R12 timing read ignored", mode, 0);
      cmd(3'b000, 1'b1, 4'b0000);
      cmd(3'b101, 1'b1, 4'b0101);
      cmd(TIM, 1'b1, 4'h0);
      eq("R12 normal after write", mode, 1);
      cmd(3'b000, 1'b1, 4'b0101);
      eq("R12 arm in nreq not kept", mode, 1);
      eq("R12 batt untouched by writes", batt_fail, 1);
   endtask

   task automatic t_block();
      int w;
      power_up();
      cycles_until(1'b0, w);
      cmd(TIM, 1'b1, 4'h0);
      repeat (RL) @(negedge clk);
      eq("R11 write in pulse ignored: mode", mode, 0);
      eq("R11 write in pulse ignored: fault", fault_n, 0);
   endtask

   initial begin
      t_reset();
      t_periodic();
      t_kick();
      t_debug();
      t_locked();
      t_ignore();
      t_block();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule